// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs MII management transactions against an external PHY on behalf of software. Software loads one 32-bit command word with a single write strobe. The word already holds the management frame in transmit order: start, opcode, PHY address, register address, turnaround and 16 data bits. The block sends an optional run of 32 preamble ones and then shifts the word out MSB first on MDIO. MDC comes from a programmable divider of the system clock.

For a read, the block releases MDIO for the turnaround and data bits. It then shifts the bits returned by the PHY into the low half of the same register. Completion raises a sticky event flag, which software clears by pulsing a clear input, the write-one-to-clear path. The command, clear and status pins are plain level or strobe signals. No path through the block carries streamed data, so there is no valid/ready back-pressure: a command offered while the block is busy is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command word is sent MSB first. Bits [31:30] are the start field, [29:28] the opcode (2'b10 means read; any other value is treated as a write), [27:23] the PHY address, [22:18] the register address, [17:16] the turnaround and [15:0] the data.
- R2: A `cmd_we` pulse while `busy` is low starts a transaction, and `busy` is high from the next cycle until the frame ends. A `cmd_we` while `busy` is high is ignored.
- R3: With `half_period` = S > 0, each frame bit holds MDC low for S clocks and then high for S clocks. MDC is low and `mdio_oe` is low whenever the block is idle.
- R4: With `half_period` = 0, MDC does not toggle and the frame does not advance.
- R5: A frame starts with 32 one bits unless `pre_sup` is high in the launch cycle, in which case it starts directly at bit 31 of the word.
- R6: While driven, `mdio_o` changes only in the cycle after MDC falls, or at launch.
- R7: For a read, `mdio_oe` is low during word bits 17..0. `mdio_i` is sampled in the cycle in which MDC rises for bits 15..0, and after completion `cmd_rdata[15:0]` holds those bits, MSB first.
- R8: For a write, every word bit is driven, and `cmd_rdata` still equals the command word after completion.
- R9: `done_evt` is set when a frame ends and stays set until an `evt_clr` pulse clears it.
- R10: In reset, `busy`, `mdc`, `mdio_oe` and `done_evt` are 0 and `cmd_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Command/data register contents |
| evt_clr | input | 1 | Clears the completion flag (write-one-to-clear) |
| done_evt | output | 1 | Sticky completion flag |
| busy | output | 1 | Transaction in progress |
| half_period | input | DIV_W | MDC half period in clocks; 0 holds MDC |
| pre_sup | input | 1 | Suppress the 32-bit preamble |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check the following on every cycle:
- MDC is quiet while idle or when the half period is zero.
- MDIO output changes only at MDC falling edges.
- An ignored command leaves the upper half of the register unchanged.
- The flag is raised at the end of every frame and holds until it is cleared.

Only the bench scenarios can show the rest. These are the exact bit sequence with and without preamble, the MDC phase lengths for several divider settings, the read capture ordering and the recovery of a frame stalled at a zero divider. The bench shows them by comparing MDC, enable and data against a queued reference waveform on every clock.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int WORD_W    = 32;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + WORD_W;
  localparam int DATA_W    = 16;
  localparam int TA_HI     = 17;
  localparam int OP_HI     = 29;
  localparam int OP_LO     = 28;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int IDX_W     = $clog2(WORD_W);

  typedef enum logic [1:0] {
    MGMT_OP_WRITE = 2'b01,
    MGMT_OP_READ  = 2'b10
  } mgmt_op_e;
endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_period,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // A tick ends one MDC half period; zero period never ticks.
  assign tick = en && (half_period != '0) && (cnt_q >= half_period - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                  cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_req,
  input  logic [WORD_W-1:0] launch_word,
  input  logic              launch_pre,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [WORD_W-1:0] word,
  output logic              done_pulse
);
  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx;
  logic             in_pre, is_read, released, sample_now, last_bit;

  assign in_pre     = pos_q < POS_W'(PRE_LEN);
  assign idx        = IDX_W'(POS_W'(FRAME_LEN - 1) - pos_q);
  assign is_read    = word[OP_HI:OP_LO] == MGMT_OP_READ;
  assign released   = is_read && !in_pre && (idx <= IDX_W'(TA_HI));
  assign sample_now = is_read && !in_pre && (idx < IDX_W'(DATA_W));
  assign last_bit   = pos_q == POS_W'(FRAME_LEN - 1);

  assign mdio_oe    = busy && !released;
  assign mdio_o     = (!mdio_oe || in_pre) ? 1'b1 : word[idx];
  assign done_pulse = busy && tick && mdc && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      mdc   <= 1'b0;
      pos_q <= '0;
      word  <= '0;
    end else if (!busy) begin
      mdc <= 1'b0;
      if (launch_req) begin
        busy  <= 1'b1;
        pos_q <= launch_pre ? '0 : POS_W'(PRE_LEN);
        word  <= launch_word;
      end
    end else if (tick) begin
      if (!mdc) begin
        mdc <= 1'b1;
        if (sample_now) word[DATA_W-1:0] <= {word[DATA_W-2:0], mdio_i};
      end else begin
        mdc <= 1'b0;
        if (last_bit) busy <= 1'b0;
        else          pos_q <= pos_q + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_evt_flag.sv
module mdio_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic [WORD_W-1:0] cmd_rdata,
  input  logic              evt_clr,
  output logic              done_evt,
  output logic              busy,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              pre_sup,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic tick, done_pulse;

  mdc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy), .half_period(half_period), .tick(tick)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch_req(cmd_we), .launch_word(cmd_wdata), .launch_pre(!pre_sup),
    .tick(tick), .mdio_i(mdio_i),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .word(cmd_rdata), .done_pulse(done_pulse)
  );

  mdio_evt_flag u_evt (
    .clk(clk), .rst_n(rst_n), .set(done_pulse), .clr(evt_clr), .flag(done_evt)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [31:0]      cmd_rdata,
  input logic             evt_clr,
  input logic             done_evt,
  input logic             busy,
  input logic [DIV_W-1:0] half_period,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_zero_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_period == '0) |=> $stable(mdc));

  assert_change_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

  assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> (cmd_rdata[31:16] == $past(cmd_rdata[31:16])));

  assert_done_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_evt);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !evt_clr) |=> done_evt);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_we = 1'b0;
  logic [31:0]   cmd_wdata = '0;
  logic [31:0]   cmd_rdata;
  logic          evt_clr = 1'b0;
  logic          done_evt, busy, mdc, mdio_o, mdio_oe;
  logic [DW-1:0] half_period = DW'(2);
  logic          pre_sup = 1'b0;
  logic          mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.DIV_W(DW)) i_mdio_mgmt_master (.*);

  int errs = 0, checks = 0, busy_cycles = 0;
  bit model_on = 1'b1, evt_m = 1'b0, done_run = 1'b0;
  logic [3:0] q[$]; // {mdc, oe, o, drive-in}

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run;
    if (!done_run) begin
      done_run = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic push_bit(input logic oe, input logic o, input logic drv, input int s);
    for (int k = 0; k < s; k++) q.push_back({1'b0, oe, o, drv});
    for (int k = 0; k < s; k++) q.push_back({1'b1, oe, o, drv});
  endtask

  task automatic push_frame(input logic [31:0] w, input bit pre, input int s,
                            input logic [15:0] phy);
    bit rd;
    rd = (w[29:28] == 2'b10);
    if (pre) for (int b = 0; b < 32; b++) push_bit(1'b1, 1'b1, 1'b1, s);
    for (int i = 31; i >= 0; i--)
      push_bit(!(rd && i <= 17), w[i], (rd && i <= 15) ? phy[i] : 1'b1, s);
  endtask

  logic [15:0] phy_data = 16'h0;

  task automatic cyc(input logic we, input logic [31:0] wd, input logic clr);
    bit was_busy, ev_next;
    logic [3:0] e;
    @(negedge clk);
    was_busy = 1'b0;
    ev_next  = 1'b0;
    if (busy) busy_cycles++;
    if (model_on) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        was_busy = 1'b1;
        chk("R2 busy", {31'd0, busy}, 32'd1);
        chk("R3 mdc", {31'd0, mdc}, {31'd0, e[3]});
        chk("R7 oe", {31'd0, mdio_oe}, {31'd0, e[2]});
        if (e[2]) chk("R1/R5/R6 mdio_o", {31'd0, mdio_o}, {31'd0, e[1]});
        mdio_i = e[0];
        if (q.size() == 0) ev_next = 1'b1;
      end else begin
        chk("R2 idle busy", {31'd0, busy}, 32'd0);
        chk("R3 idle mdc/oe", {30'd0, mdc, mdio_oe}, 32'd0);
        mdio_i = 1'b1;
      end
      chk("R9 done_evt", {31'd0, done_evt}, {31'd0, evt_m});
    end else begin
      mdio_i = 1'b1;
    end
    if (clr) evt_m = 1'b0;
    if (ev_next) evt_m = 1'b1;
    cmd_we    = we;
    cmd_wdata = wd;
    evt_clr   = clr;
    if (model_on && we && !was_busy) push_frame(wd, !pre_sup, int'(half_period), phy_data);
  endtask

  task automatic drain;
    while (q.size() > 0) cyc(1'b0, 32'h0, 1'b0);
    cyc(1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {28'd0, busy, mdc, mdio_oe, done_evt}, 32'd0);
    chk("R10 reset rdata", cmd_rdata, 32'd0);
    rst_n = 1'b1;
    cyc(1'b0, 0, 1'b0);

    // Write with preamble, S=2 (R1, R5, R8)
    half_period = DW'(2);
    w = {2'b01, 2'b01, 5'd5, 5'd10, 2'b10, 16'hBEEF};
    busy_cycles = 0;
    cyc(1'b1, w, 1'b0);
    drain();
    chk("R3 write frame length S=2", busy_cycles, 64 * 4);
    chk("R8 rdata after write", cmd_rdata, w);
    chk("R9 flag set after write", {31'd0, done_evt}, 32'd1);
    cyc(1'b0, 0, 1'b1);
    cyc(1'b0, 0, 1'b0);
    chk("R9 flag cleared", {31'd0, done_evt}, 32'd0);

    // Read with preamble, S=3, ignored write mid-frame (R2, R7)
    half_period = DW'(3);
    phy_data = 16'hA5C3;
    w = {2'b01, 2'b10, 5'd1, 5'd2, 2'b11, 16'h0000};
    busy_cycles = 0;
    cyc(1'b1, w, 1'b0);
    repeat (40) cyc(1'b0, 0, 1'b0);
    cyc(1'b1, 32'h5FFF_1234, 1'b0);
    drain();
    chk("R3 read frame length S=3", busy_cycles, 64 * 6);
    chk("R7 read data captured", {16'd0, cmd_rdata[15:0]}, 32'h0000A5C3);
    chk("R2 ignored write kept header", {16'd0, cmd_rdata[31:16]}, {16'd0, w[31:16]});
    cyc(1'b0, 0, 1'b1);

    // Read without preamble, S=1 (R5, R7)
    half_period = DW'(1);
    pre_sup = 1'b1;
    phy_data = 16'h8001;
    w = {2'b01, 2'b10, 5'd31, 5'd0, 2'b00, 16'hFFFF};
    busy_cycles = 0;
    cyc(1'b1, w, 1'b0);
    drain();
    chk("R5 no-preamble frame length", busy_cycles, 32 * 2);
    chk("R7 edge data captured", {16'd0, cmd_rdata[15:0]}, 32'h00008001);
    cyc(1'b0, 0, 1'b1);

    // Write, preamble suppressed, S=4, PHY drives garbage (R8)
    half_period = DW'(4);
    phy_data = 16'h0000;
    w = {2'b01, 2'b01, 5'd0, 5'd31, 2'b10, 16'h0001};
    cyc(1'b1, w, 1'b0);
    drain();
    chk("R8 write rdata unchanged", cmd_rdata, w);
    pre_sup = 1'b0;
    cyc(1'b0, 0, 1'b1);

    // Zero divider holds the frame (R4)
    model_on = 1'b0;
    half_period = '0;
    cyc(1'b1, {2'b01, 2'b01, 5'd3, 5'd3, 2'b10, 16'h1234}, 1'b0);
    begin
      int seen_mdc = 0;
      for (int k = 0; k < 30; k++) begin
        cyc(1'b0, 0, 1'b0);
        if (mdc) seen_mdc++;
      end
      chk("R4 mdc held low", seen_mdc, 0);
      chk("R4 frame stalled busy", {31'd0, busy}, 32'd1);
    end
    half_period = DW'(1);
    begin
      int n = 0;
      while (busy && n < 1000) begin cyc(1'b0, 0, 1'b0); n++; end
    end
    cyc(1'b0, 0, 1'b0);
    chk("R4 resumes and finishes", {30'd0, busy, done_evt}, 32'd1);
    cyc(1'b0, 0, 1'b1);
    cyc(1'b0, 0, 1'b0);
    chk("R9 flag cleared after stall", {31'd0, done_evt}, 32'd0);
    evt_m = 1'b0;
    model_on = 1'b1;
    repeat (4) cyc(1'b0, 0, 1'b0);
    finish_run();
  end
endmodule